// File: doc/BRIEF.md
# Halting Down-Counter Timer with Optional Reload

This block is a count-down timer for a processor's timer unit. Each cycle in which the tick-enable input is high, it lowers its count by one. When the count reaches zero it latches a sticky expiry flag and holds at zero. It never wraps to all ones, and the count's top bit has no special role. If automatic reload is enabled, the expiry tick loads the count from a separate reload register, and counting goes on from that value.

Software reaches the block through four write strobes: the count, the reload value, a control word and a status word. Status bits are cleared by writing a one to them. The interrupt output is a level, high whenever the expiry flag and the interrupt enable are both set. Because the level depends only on those two, enabling the interrupt after an expiry that went unserviced raises it at once. The tick source and the interrupt controller are outside this block.

Top module: `halt_dec_timer`

## Requirements
- R1: A cycle with `tick_en` high and a non-zero count lowers the count by one. Without a tick, the count holds.
- R2: At zero the count stays at zero on further ticks. It never wraps to all ones. It leaves zero only by a software write, or by a reload on the expiry tick.
- R3: The tick that takes the count from 1 to 0 sets the expiry flag (status bit 27), whatever the interrupt enable is. A software write of 0 to the count does not set the flag.
- R4: With auto-reload on (control bit 22), the expiry tick loads the reload register's value into the count instead of 0, and later ticks keep counting down from it.
- R5: With auto-reload on and a reload value of 0, the flag is set once at expiry. The count then stays at 0 and no further expiry occurs.
- R6: `irq` is high exactly while the expiry flag and the interrupt enable (control bit 26) are both set. Setting the enable while the flag is already set raises `irq` in the cycle after the control write.
- R7: A status write with bit 27 set clears the expiry flag. Writing 0 to bit 27 leaves it unchanged, whatever the other bits hold. An expiry in the same cycle as a clear wins.
- R8: Writing a count with bit 31 set raises no interrupt. After expiry without reload, the count reads back as 0.
- R9: A software count write in the same cycle as a tick takes the written value, and the tick is dropped.
- R10: Synchronous reset clears the count, the reload value, the control word and the flag, so `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base tick, one decrement per high cycle |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write value |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | 32 | Reload register write value |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word (bit 26 interrupt enable, bit 22 auto-reload) |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 32 | Status write value, one in bit 27 clears the flag |
| cnt_rdata | output | 32 | Current count |
| irq | output | 1 | Level interrupt |

## Verification
The bench keeps ticking after the count reaches zero. A wrapping counter would show all ones there, and a counter that never stopped would raise a second expiry. It loads a count with bit 31 set, to catch a design that takes the top bit as an interrupt, and a count of zero, to catch an expiry caused by a write. It checks that a reload lands on the expiry tick and not one tick later. Status writes with every bit but 27 set must leave the interrupt up. Enabling the interrupt after an expiry that was left pending must raise it at once, which an edge-triggered design would miss.

// File: rtl/hdt_pkg.sv
package hdt_pkg;

    localparam int HDT_W        = 32;
    localparam int HDT_IE_POS   = 26;
    localparam int HDT_ARE_POS  = 22;
    localparam int HDT_FLAG_POS = 27;

    typedef struct packed {
        logic irq_en;
        logic auto_rld;
    } hdt_ctl_t;

    function automatic hdt_ctl_t hdt_decode_ctl(input logic [HDT_W-1:0] word);
        hdt_ctl_t c;
        c.irq_en   = word[HDT_IE_POS];
        c.auto_rld = word[HDT_ARE_POS];
        return c;
    endfunction

endpackage

// File: rtl/hdt_regs.sv
module hdt_regs
    import hdt_pkg::*;
#(
    parameter int W = HDT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rld_wr,
    input  logic [W-1:0] rld_wdata,
    input  logic         ctl_wr,
    input  logic [W-1:0] ctl_wdata,
    output hdt_ctl_t     ctl,
    output logic [W-1:0] reload
);

    hdt_ctl_t     ctl_q;
    logic [W-1:0] rld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            rld_q <= '0;
        end else begin
            if (ctl_wr) ctl_q <= hdt_decode_ctl(ctl_wdata);
            if (rld_wr) rld_q <= rld_wdata;
        end
    end

    assign ctl    = ctl_q;
    assign reload = rld_q;

    // R6: the enable follows the control write on the next cycle
    p_ctl_write_r6: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_q.irq_en == $past(ctl_wdata[HDT_IE_POS])));

endmodule

// File: rtl/hdt_core.sv
module hdt_core
    import hdt_pkg::*;
#(
    parameter int W = HDT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  hdt_ctl_t     ctl,
    input  logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic         expire
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q, cnt_d;
    logic         exp_d;

    always_comb begin
        cnt_d = cnt_q;
        exp_d = 1'b0;
        if (cnt_wr) begin
            cnt_d = cnt_wdata;
        end else if (tick_en && (cnt_q != '0)) begin
            if (cnt_q == ONE) begin
                exp_d = 1'b1;
                cnt_d = ctl.auto_rld ? reload : '0;
            end else begin
                cnt_d = cnt_q - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt    = cnt_q;
    assign expire = exp_d;

    // R2: zero is held unless software writes
    p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q == '0) && !cnt_wr) |=> (cnt_q == '0));
    // R1: one step per tick
    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cnt_wr && (cnt_q > ONE)) |=> (cnt_q == $past(cnt_q) - ONE));
    // R4: reload lands on the expiry tick
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !cnt_wr && (cnt_q == ONE) && ctl.auto_rld) |=> (cnt_q == $past(reload)));
    // R9: software write beats the tick
    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt_q == $past(cnt_wdata)));

endmodule

// File: rtl/hdt_status.sv
module hdt_status
    import hdt_pkg::*;
#(
    parameter int W = HDT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         expire,
    input  logic         sts_wr,
    input  logic [W-1:0] sts_wdata,
    input  hdt_ctl_t     ctl,
    output logic         irq
);

    logic flag_q;
    logic clr;

    assign clr = sts_wr && sts_wdata[HDT_FLAG_POS];

    always_ff @(posedge clk) begin
        if (rst)         flag_q <= 1'b0;
        else if (expire) flag_q <= 1'b1;
        else if (clr)    flag_q <= 1'b0;
    end

    assign irq = flag_q && ctl.irq_en;

    // R3: expiry always latches the flag
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);
    // R3: nothing but expiry sets the flag
    p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
        (!expire && !flag_q) |=> !flag_q);
    // R7: write-one clears
    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && !expire) |=> !flag_q);
    // R7: a status write without bit 27 keeps the flag
    p_w0_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

endmodule

// File: rtl/halt_dec_timer.sv
module halt_dec_timer
    import hdt_pkg::*;
#(
    parameter int W = HDT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         rld_wr,
    input  logic [W-1:0] rld_wdata,
    input  logic         ctl_wr,
    input  logic [W-1:0] ctl_wdata,
    input  logic         sts_wr,
    input  logic [W-1:0] sts_wdata,
    output logic [W-1:0] cnt_rdata,
    output logic         irq
);

    hdt_ctl_t     ctl;
    logic [W-1:0] reload;
    logic         expire;

    hdt_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .rld_wr    (rld_wr),
        .rld_wdata (rld_wdata),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl       (ctl),
        .reload    (reload)
    );

    hdt_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .ctl       (ctl),
        .reload    (reload),
        .cnt       (cnt_rdata),
        .expire    (expire)
    );

    hdt_status #(.W(W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .sts_wr    (sts_wr),
        .sts_wdata (sts_wdata),
        .ctl       (ctl),
        .irq       (irq)
    );

    // R8: an interrupt rises only together with an expiry or an enable write
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (!irq && !expire && !ctl_wr) |=> !irq);

endmodule

// File: tb/halt_dec_timer_bench.sv
`timescale 1ns/1ps
module halt_dec_timer_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick_en, cnt_wr, rld_wr, ctl_wr, sts_wr;
    logic [31:0] cnt_wdata, rld_wdata, ctl_wdata, sts_wdata;
    logic [31:0] cnt_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    halt_dec_timer u_halt_dec_timer (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .cnt_rdata(cnt_rdata), .irq(irq)
    );

    // op: 0 idle, 1 tick, 2 count write, 3 reload write, 4 control write,
    //     5 status write, 6 count write together with a tick
    // fields: op[75:73] data[72:41] exp_cnt[40:9] exp_irq[8] req[7:0]
    localparam int NV = 34;
    localparam logic [75:0] VEC [NV] = '{
        {3'd4, 32'h0400_0000, 32'h0000_0000, 1'b0, 8'd6},  // R6 enable on
        {3'd2, 32'h0000_0003, 32'h0000_0003, 1'b0, 8'd9},  // R9 load 3
        {3'd1, 32'h0,         32'h0000_0002, 1'b0, 8'd1},  // R1
        {3'd0, 32'h0,         32'h0000_0002, 1'b0, 8'd1},  // R1 hold
        {3'd1, 32'h0,         32'h0000_0001, 1'b0, 8'd1},  // R1
        {3'd1, 32'h0,         32'h0000_0000, 1'b1, 8'd3},  // R3 expiry
        {3'd1, 32'h0,         32'h0000_0000, 1'b1, 8'd2},  // R2 no wrap
        {3'd5, 32'h0000_0000, 32'h0000_0000, 1'b1, 8'd7},  // R7 zero write
        {3'd5, 32'hF7FF_FFFF, 32'h0000_0000, 1'b1, 8'd7},  // R7 other bits
        {3'd5, 32'h0800_0000, 32'h0000_0000, 1'b0, 8'd7},  // R7 clear
        {3'd2, 32'h8000_0002, 32'h8000_0002, 1'b0, 8'd8},  // R8 top bit
        {3'd1, 32'h0,         32'h8000_0001, 1'b0, 8'd8},  // R8
        {3'd6, 32'h0000_0005, 32'h0000_0005, 1'b0, 8'd9},  // R9 write wins
        {3'd2, 32'h0000_0000, 32'h0000_0000, 1'b0, 8'd3},  // R3 write 0
        {3'd1, 32'h0,         32'h0000_0000, 1'b0, 8'd2},  // R2
        {3'd3, 32'h0000_0004, 32'h0000_0000, 1'b0, 8'd4},  // R4 reload 4
        {3'd4, 32'h0440_0000, 32'h0000_0000, 1'b0, 8'd4},  // R4 on
        {3'd2, 32'h0000_0001, 32'h0000_0001, 1'b0, 8'd4},
        {3'd1, 32'h0,         32'h0000_0004, 1'b1, 8'd4},  // R4 reload
        {3'd1, 32'h0,         32'h0000_0003, 1'b1, 8'd4},  // R4 continue
        {3'd5, 32'h0800_0000, 32'h0000_0003, 1'b0, 8'd7},  // R7
        {3'd4, 32'h0000_0000, 32'h0000_0003, 1'b0, 8'd6},
        {3'd1, 32'h0,         32'h0000_0002, 1'b0, 8'd1},
        {3'd1, 32'h0,         32'h0000_0001, 1'b0, 8'd1},
        {3'd1, 32'h0,         32'h0000_0000, 1'b0, 8'd3},  // R3 masked expiry
        {3'd4, 32'h0400_0000, 32'h0000_0000, 1'b1, 8'd6},  // R6 late enable
        {3'd5, 32'h0800_0000, 32'h0000_0000, 1'b0, 8'd7},  // R7
        {3'd3, 32'h0000_0000, 32'h0000_0000, 1'b0, 8'd5},  // R5 reload 0
        {3'd4, 32'h0440_0000, 32'h0000_0000, 1'b0, 8'd5},
        {3'd2, 32'h0000_0002, 32'h0000_0002, 1'b0, 8'd5},
        {3'd1, 32'h0,         32'h0000_0001, 1'b0, 8'd5},
        {3'd1, 32'h0,         32'h0000_0000, 1'b1, 8'd5},  // R5 expiry once
        {3'd5, 32'h0800_0000, 32'h0000_0000, 1'b0, 8'd5},
        {3'd1, 32'h0,         32'h0000_0000, 1'b0, 8'd5}   // R5 no repeat
    };

    task automatic idle_inputs();
        tick_en = 1'b0; cnt_wr = 1'b0; rld_wr = 1'b0; ctl_wr = 1'b0; sts_wr = 1'b0;
        cnt_wdata = '0; rld_wdata = '0; ctl_wdata = '0; sts_wdata = '0;
    endtask

    task automatic check(input int req, input logic [31:0] ec, input logic ei);
        total++;
        if (cnt_rdata !== ec || irq !== ei) begin
            bad++;
            $display("FAIL R%0d: cnt=%h irq=%b expected cnt=%h irq=%b",
                     req, cnt_rdata, irq, ec, ei);
        end
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL R0: watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(10, 32'h0, 1'b0);  // R10 reset state

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [31:0] d;
            op = VEC[i][75:73];
            d  = VEC[i][72:41];
            idle_inputs();
            case (op)
                3'd1: tick_en = 1'b1;
                3'd2: begin cnt_wr = 1'b1; cnt_wdata = d; end
                3'd3: begin rld_wr = 1'b1; rld_wdata = d; end
                3'd4: begin ctl_wr = 1'b1; ctl_wdata = d; end
                3'd5: begin sts_wr = 1'b1; sts_wdata = d; end
                3'd6: begin cnt_wr = 1'b1; cnt_wdata = d; tick_en = 1'b1; end
                default: ;
            endcase
            @(negedge clk);
            check(int'(VEC[i][7:0]), VEC[i][40:9], VEC[i][8]);
        end

        // R7: expiry in the same cycle as a clear keeps the flag
        idle_inputs();
        ctl_wr = 1'b1; ctl_wdata = 32'h0400_0000;
        @(negedge clk);
        idle_inputs();
        cnt_wr = 1'b1; cnt_wdata = 32'h1;
        @(negedge clk);
        idle_inputs();
        tick_en = 1'b1; sts_wr = 1'b1; sts_wdata = 32'h0800_0000;
        @(negedge clk);
        idle_inputs();
        check(7, 32'h0, 1'b1);

        // R10: reset in mid-run clears everything
        cnt_wr = 1'b1; cnt_wdata = 32'h7;
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(10, 32'h0, 1'b0);
        // R10: control cleared, so a fresh expiry stays silent
        cnt_wr = 1'b1; cnt_wdata = 32'h1;
        @(negedge clk);
        idle_inputs();
        tick_en = 1'b1;
        @(negedge clk);
        idle_inputs();
        check(10, 32'h0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule